// File: doc/BRIEF.md
# Compare-Match Watchdog Timer

This block is a register-mapped watchdog. A 32-bit up-counter advances by one on each pulse of a tick-enable input. The tick-enable is derived elsewhere from a fixed 13 MHz reference. Software sets a match value. Each time the running counter equals that value, the block can flag an interrupt, halt the counter, change an external match pin, and start a reset pulse on the internal line, the external line or both.

The pulse length comes from a 16-bit register plus a fixed extra of six ticks. A software-written bit can also hold either reset line high directly, with no match needed. A sticky cause bit records that the watchdog drove a reset line. Only the power-on reset clears it.

A debug input can freeze counting while a control bit allows it. Software restarts the timeout by clearing the counter and then enabling it again. It can poll the counter register to see the clear take effect.

Top module: `wdogMatchTimer`

## Requirements
- R1: After power-on reset, all eight registers read 0 and the outputs matchIrq, matchOut, intRstOut and extRstOut are low.
- R2: The control register is at byte offset 0x04 and the counter is at 0x08. While control bit 0 is 1, control bit 1 is 0 and no debug freeze applies, the counter increments once per clock in which tickEn is 1. It holds when tickEn is 0.
- R3: While control bit 1 is 1, the counter reads back 0 from one clock after the write. Writing 0 to the control register stops the counter at its present value.
- R4: While control bit 2 is 1 and dbgActive is 1, the counter does not advance. When either is 0, the counter counts normally.
- R5: A match is a tick in which counting is enabled and the counter equals the match register (offset 0x10). A match sets bit 0 of the flag register at offset 0x00. Writing 1 to that bit clears it. matchIrq is high while the flag is set and bit 0 of the match-action register (offset 0x0C) is 1. No match occurs while counting is disabled.
- R6: With match-action bit 2 set, a match leaves the counter at the match value and clears control bit 0. With that bit clear, the counter keeps counting past the match.
- R7: The pin register is at offset 0x14. Its bit 0 drives matchOut and reads back the pin level. Its bits 5:4 give the action taken on a match: 0 keeps the pin, 1 drives it low, 2 drives it high and 3 toggles it.
- R8: On a match, match-action bit 3 starts a pulse on intRstOut and bit 4 starts one on extRstOut. Each pulse lasts the pulse register (offset 0x18, 16 bits) plus 6 ticks.
- R9: Match-action bit 5 holds intRstOut high and bit 6 holds extRstOut high, for as long as the bit is set.
- R10: Bit 0 of the cause register at offset 0x1C becomes 1 once either reset output has been high. Only power-on reset clears it.
- R11: Writes to the counter offset and to the cause offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstPorN | input | 1 | Active-low power-on reset |
| tickEn | input | 1 | Counter tick enable, one clock wide per tick |
| dbgActive | input | 1 | High while a debugger halts the system |
| regAddr | input | 5 | Register byte address |
| regWe | input | 1 | Write strobe, one clock per write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| matchIrq | output | 1 | Match interrupt request |
| matchOut | output | 1 | External match pin |
| intRstOut | output | 1 | Internal reset request |
| extRstOut | output | 1 | External reset request |

## Verification
Errors in the counter or in how run is gated show up on the counter readback within a few ticks. They also move the match point, which changes the cycle in which the flag, the pin and the pulses start. Errors in the pulse counter change the number of clocks for which a reset line stays high, so the bench counts that width exactly. Losing the sticky cause bit shows up the next time software reads the cause register. It also shows up after a fresh power-on reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // word indexes (byte offset / 4); the bit layout inside each word is fixed by software
  localparam logic [2:0] IDX_FLAG  = 3'd0;
  localparam logic [2:0] IDX_CTRL  = 3'd1;
  localparam logic [2:0] IDX_COUNT = 3'd2;
  localparam logic [2:0] IDX_ACT   = 3'd3;
  localparam logic [2:0] IDX_MATCH = 3'd4;
  localparam logic [2:0] IDX_PIN   = 3'd5;
  localparam logic [2:0] IDX_PULSE = 3'd6;
  localparam logic [2:0] IDX_CAUSE = 3'd7;

  typedef struct packed {
    logic run;        // counting permitted this clock
    logic clear;      // hold counter at zero
    logic holdOnHit;  // suppress increment on a match
    logic pulseLoad;  // start reset pulse
  } wdtStrobe_t;
endpackage

// File: rtl/wdtDatapath.sv
module wdtDatapath
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PULSE_W     = 16,
  parameter int PULSE_EXTRA = 6
) (
  input  logic               clk,
  input  logic               rstPorN,
  input  logic               tickEn,
  input  wdtStrobe_t         strb,
  input  logic [CNT_W-1:0]   matchVal,
  input  logic [PULSE_W-1:0] pulseLen,
  output logic [CNT_W-1:0]   counterVal,
  output logic               hitNow,
  output logic               pulseActive
);
  localparam int PCNT_W = $clog2((1 << PULSE_W) + PULSE_EXTRA);

  logic [PCNT_W-1:0] pulseCnt;

  assign hitNow      = strb.run && tickEn && (counterVal == matchVal);
  assign pulseActive = (pulseCnt != '0);

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      counterVal <= '0;
    end else if (strb.clear) begin
      counterVal <= '0;
    end else if (strb.run && tickEn && !(hitNow && strb.holdOnHit)) begin
      counterVal <= counterVal + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      pulseCnt <= '0;
    end else if (strb.pulseLoad) begin
      pulseCnt <= PCNT_W'(pulseLen) + PCNT_W'(PULSE_EXTRA);
    end else if (tickEn && pulseActive) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdtControl.sv
module wdtControl
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PULSE_W = 16,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rstPorN,
  input  logic               dbgActive,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWe,
  input  logic [CNT_W-1:0]   regWdata,
  output logic [CNT_W-1:0]   regRdata,
  input  logic [CNT_W-1:0]   counterVal,
  input  logic               hitNow,
  input  logic               pulseActive,
  output wdtStrobe_t         strb,
  output logic [CNT_W-1:0]   matchVal,
  output logic [PULSE_W-1:0] pulseLen,
  output logic               matchFlag,
  output logic               rstCause,
  output logic               ctrlEn,
  output logic               matchIrq,
  output logic               matchOut,
  output logic               intRstOut,
  output logic               extRstOut
);
  localparam int IDX_W = ADDR_W - 2;

  logic [2:0]       ctrlReg;
  logic [6:0]       actReg;
  logic [1:0]       pinAct;
  logic             intSel;
  logic             extSel;
  logic [IDX_W-1:0] wordIdx;
  logic             wrCtrl;

  assign wordIdx = regAddr[ADDR_W-1:2];
  assign wrCtrl  = regWe && (wordIdx == IDX_W'(IDX_CTRL));
  assign ctrlEn  = ctrlReg[0];

  assign strb.clear     = ctrlReg[1];
  assign strb.run       = ctrlReg[0] && !ctrlReg[1] && !(ctrlReg[2] && dbgActive);
  assign strb.holdOnHit = actReg[2];
  assign strb.pulseLoad = hitNow && (actReg[3] || actReg[4]);

  assign matchIrq  = matchFlag && actReg[0];
  assign intRstOut = (pulseActive && intSel) || actReg[5];
  assign extRstOut = (pulseActive && extSel) || actReg[6];

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      ctrlReg   <= '0;
      actReg    <= '0;
      matchVal  <= '0;
      pulseLen  <= '0;
      pinAct    <= '0;
      matchOut  <= 1'b0;
      matchFlag <= 1'b0;
      intSel    <= 1'b0;
      extSel    <= 1'b0;
      rstCause  <= 1'b0;
    end else begin
      if (wrCtrl) ctrlReg <= regWdata[2:0];
      else if (hitNow && actReg[2]) ctrlReg[0] <= 1'b0;

      if (regWe && wordIdx == IDX_W'(IDX_ACT))   actReg   <= regWdata[6:0] & 7'b1111101;
      if (regWe && wordIdx == IDX_W'(IDX_MATCH)) matchVal <= regWdata;
      if (regWe && wordIdx == IDX_W'(IDX_PULSE)) pulseLen <= regWdata[PULSE_W-1:0];

      if (regWe && wordIdx == IDX_W'(IDX_PIN)) begin
        matchOut <= regWdata[0];
        pinAct   <= regWdata[5:4];
      end else if (hitNow) begin
        case (pinAct)
          2'd1:    matchOut <= 1'b0;
          2'd2:    matchOut <= 1'b1;
          2'd3:    matchOut <= !matchOut;
          default: matchOut <= matchOut;
        endcase
      end

      if (hitNow) matchFlag <= 1'b1;
      else if (regWe && wordIdx == IDX_W'(IDX_FLAG) && regWdata[0]) matchFlag <= 1'b0;

      if (strb.pulseLoad) begin
        intSel <= actReg[3];
        extSel <= actReg[4];
      end

      if (intRstOut || extRstOut) rstCause <= 1'b1;
    end
  end

  always_comb begin
    regRdata = '0;
    case (wordIdx)
      IDX_W'(IDX_FLAG):  regRdata[0]   = matchFlag;
      IDX_W'(IDX_CTRL):  regRdata[2:0] = ctrlReg;
      IDX_W'(IDX_COUNT): regRdata      = counterVal;
      IDX_W'(IDX_ACT):   regRdata[6:0] = actReg;
      IDX_W'(IDX_MATCH): regRdata      = matchVal;
      IDX_W'(IDX_PIN):   regRdata[5:0] = {pinAct, 3'b000, matchOut};
      IDX_W'(IDX_PULSE): regRdata[PULSE_W-1:0] = pulseLen;
      default:           regRdata[0]   = rstCause;
    endcase
  end
endmodule

// File: rtl/wdogMatchTimer.sv
module wdogMatchTimer
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PULSE_W     = 16,
  parameter int PULSE_EXTRA = 6,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rstPorN,
  input  logic              tickEn,
  input  logic              dbgActive,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  output logic              matchIrq,
  output logic              matchOut,
  output logic              intRstOut,
  output logic              extRstOut
);
  wdtStrobe_t         strb;
  logic [CNT_W-1:0]   counterVal;
  logic [CNT_W-1:0]   matchVal;
  logic [PULSE_W-1:0] pulseLen;
  logic               hitNow;
  logic               pulseActive;
  logic               matchFlag;
  logic               rstCause;
  logic               ctrlEn;

  wdtControl #(.CNT_W(CNT_W), .PULSE_W(PULSE_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstPorN(rstPorN), .dbgActive(dbgActive),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .counterVal(counterVal), .hitNow(hitNow), .pulseActive(pulseActive),
    .strb(strb), .matchVal(matchVal), .pulseLen(pulseLen),
    .matchFlag(matchFlag), .rstCause(rstCause), .ctrlEn(ctrlEn),
    .matchIrq(matchIrq), .matchOut(matchOut),
    .intRstOut(intRstOut), .extRstOut(extRstOut)
  );

  wdtDatapath #(.CNT_W(CNT_W), .PULSE_W(PULSE_W), .PULSE_EXTRA(PULSE_EXTRA)) dp_i (
    .clk(clk), .rstPorN(rstPorN), .tickEn(tickEn), .strb(strb),
    .matchVal(matchVal), .pulseLen(pulseLen),
    .counterVal(counterVal), .hitNow(hitNow), .pulseActive(pulseActive)
  );
endmodule

// File: rtl/wdogMatchTimer_chk.sv
module wdogMatchTimer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstPorN,
  input logic             tickEn,
  input logic             regWe,
  input logic             runNow,
  input logic             clearNow,
  input logic             holdOnHit,
  input logic             hitNow,
  input logic [CNT_W-1:0] counterVal,
  input logic             matchFlag,
  input logic             ctrlEn,
  input logic             rstCause,
  input logic             intRstOut,
  input logic             extRstOut
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstPorN)
    (runNow && tickEn && !(hitNow && holdOnHit)) |=> counterVal == CNT_W'($past(counterVal) + 1'b1));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstPorN)
    (!tickEn && !clearNow) |=> $stable(counterVal));

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rstPorN)
    clearNow |=> counterVal == '0);

  assert_hit_flag_R5: assert property (@(posedge clk) disable iff (!rstPorN)
    hitNow |=> matchFlag);

  assert_stop_on_hit_R6: assert property (@(posedge clk) disable iff (!rstPorN)
    (hitNow && holdOnHit && !regWe) |=> !ctrlEn);

  assert_cause_set_R10: assert property (@(posedge clk) disable iff (!rstPorN)
    (intRstOut || extRstOut) |=> rstCause);

  assert_cause_sticky_R10: assert property (@(posedge clk) disable iff (!rstPorN)
    rstCause |=> rstCause);
endmodule

bind wdogMatchTimer wdogMatchTimer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstPorN(rstPorN), .tickEn(tickEn), .regWe(regWe),
  .runNow(strb.run), .clearNow(strb.clear), .holdOnHit(strb.holdOnHit),
  .hitNow(hitNow), .counterVal(counterVal), .matchFlag(matchFlag),
  .ctrlEn(ctrlEn), .rstCause(rstCause),
  .intRstOut(intRstOut), .extRstOut(extRstOut)
);

// File: tb/wdogMatchTimer_tb_top.sv
module wdogMatchTimer_tb_top;
  logic        clk = 1'b0;
  logic        rstPorN = 1'b0;
  logic        tickEn = 1'b0;
  logic        dbgActive = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        matchIrq, matchOut, intRstOut, extRstOut;

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 0;

  typedef struct {
    string       tag;
    int          src;   // 0 rdata, 1 matchIrq, 2 matchOut, 3 intRst, 4 extRst, 5 supplied
    logic [31:0] exp;
    logic [31:0] act;
  } item_t;

  item_t expQ[$];
  event  sampleEv;

  always #10 clk = ~clk;  // 50 MHz

  wdogMatchTimer dut_i (
    .clk(clk), .rstPorN(rstPorN), .tickEn(tickEn), .dbgActive(dbgActive),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .matchIrq(matchIrq), .matchOut(matchOut),
    .intRstOut(intRstOut), .extRstOut(extRstOut)
  );

  // monitor: pops expected items and compares against the live outputs
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = expQ.pop_front();
        case (it.src)
          0: got = regRdata;
          1: got = {31'b0, matchIrq};
          2: got = {31'b0, matchOut};
          3: got = {31'b0, intRstOut};
          4: got = {31'b0, extRstOut};
          default: got = it.act;
        endcase
        chkCnt++;
        if (got !== it.exp) begin
          errCnt++;
          $display("FAIL %s: actual=0x%08h expected=0x%08h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic push(input string tag, input int src, input logic [31:0] exp, input logic [31:0] act);
    item_t it;
    it.tag = tag; it.src = src; it.exp = exp; it.act = act;
    expQ.push_back(it);
    -> sampleEv;
    #0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic expReg(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    push(tag, 0, e, '0);
  endtask

  task automatic expPin(input int src, input logic e, input string tag);
    @(negedge clk);
    #1;
    push(tag, src, {31'b0, e}, '0);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic restart();
    wr(5'h04, 32'h2);
    wr(5'h04, 32'h1);
  endtask

  // run ticks for a window and count clocks with each reset line high
  task automatic measure(input int n, output int intHigh, output int extHigh);
    intHigh = 0; extHigh = 0;
    @(negedge clk);
    tickEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      if (intRstOut) intHigh++;
      if (extRstOut) extHigh++;
    end
    tickEn = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errCnt++; chkCnt++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    int ih, eh;
    repeat (3) @(negedge clk);
    rstPorN = 1'b1;

    // R1 reset state
    for (int k = 0; k < 8; k++) expReg(5'(k * 4), 32'h0, "R1 register reset value");
    expPin(1, 1'b0, "R1 matchIrq");
    expPin(2, 1'b0, "R1 matchOut");
    expPin(3, 1'b0, "R1 intRstOut");
    expPin(4, 1'b0, "R1 extRstOut");

    // R2 counting
    wr(5'h04, 32'h1);
    repeat (3) @(negedge clk);
    expReg(5'h08, 32'd0, "R2 no tick no count");
    ticks(5);
    expReg(5'h08, 32'd5, "R2 five ticks");

    // R3 stop and clear
    wr(5'h04, 32'h0);
    ticks(3);
    expReg(5'h08, 32'd5, "R3 control zero freezes counter");
    wr(5'h04, 32'h2);
    expReg(5'h08, 32'd0, "R3 clear visible in readback");
    expReg(5'h04, 32'h2, "R3 control readback");

    // R4 debug freeze
    wr(5'h04, 32'h5);
    dbgActive = 1'b1;
    ticks(4);
    expReg(5'h08, 32'd0, "R4 frozen while debug");
    dbgActive = 1'b0;
    ticks(4);
    expReg(5'h08, 32'd4, "R4 counts when debug low");
    wr(5'h04, 32'h1);
    dbgActive = 1'b1;
    ticks(3);
    expReg(5'h08, 32'd7, "R4 debug ignored without freeze bit");
    dbgActive = 1'b0;

    // R5 / R6 match with stop
    wr(5'h04, 32'h2);
    wr(5'h10, 32'd10);
    wr(5'h0C, 32'h05);
    wr(5'h04, 32'h1);
    ticks(20);
    expReg(5'h08, 32'd10, "R6 counter halted at match");
    expReg(5'h04, 32'h0, "R6 enable cleared by match");
    expReg(5'h00, 32'h1, "R5 flag set");
    expPin(1, 1'b1, "R5 matchIrq high");
    wr(5'h00, 32'h1);
    expReg(5'h00, 32'h0, "R5 flag cleared by write one");
    expPin(1, 1'b0, "R5 matchIrq low");

    // R6 no stop
    wr(5'h0C, 32'h01);
    restart();
    ticks(15);
    expReg(5'h08, 32'd15, "R6 counts past match");
    expReg(5'h00, 32'h1, "R5 flag on running match");
    wr(5'h00, 32'h1);
    wr(5'h04, 32'h0);
    wr(5'h10, 32'd15);
    ticks(3);
    expReg(5'h00, 32'h0, "R5 no match while disabled");
    wr(5'h0C, 32'h04);
    wr(5'h04, 32'h1);
    ticks(2);
    expReg(5'h00, 32'h1, "R5 flag without irq enable");
    expPin(1, 1'b0, "R5 matchIrq masked");
    expReg(5'h08, 32'd15, "R6 held at match");
    wr(5'h00, 32'h1);

    // R7 pin actions
    wr(5'h14, 32'h20);
    wr(5'h10, 32'd4);
    restart();
    ticks(10);
    expPin(2, 1'b1, "R7 drive high");
    expReg(5'h14, 32'h21, "R7 readback high");
    wr(5'h14, 32'h11);
    expPin(2, 1'b1, "R7 direct write of level");
    restart();
    ticks(10);
    expPin(2, 1'b0, "R7 drive low");
    expReg(5'h14, 32'h10, "R7 readback low");
    wr(5'h14, 32'h30);
    restart();
    ticks(10);
    expPin(2, 1'b1, "R7 toggle to high");
    restart();
    ticks(10);
    expPin(2, 1'b0, "R7 toggle to low");
    wr(5'h14, 32'h01);
    restart();
    ticks(10);
    expPin(2, 1'b1, "R7 no action keeps pin");
    wr(5'h14, 32'h00);
    expReg(5'h1C, 32'h0, "R10 cause clear before any reset");

    // R8 pulse width
    wr(5'h18, 32'd3);
    wr(5'h10, 32'd2);
    wr(5'h0C, 32'h0C);
    restart();
    measure(30, ih, eh);
    push("R8 internal pulse width", 5, 32'd9, 32'(ih));
    push("R8 external idle", 5, 32'd0, 32'(eh));
    expReg(5'h1C, 32'h1, "R10 cause set after pulse");
    wr(5'h0C, 32'h14);
    restart();
    measure(30, ih, eh);
    push("R8 external pulse width", 5, 32'd9, 32'(eh));
    push("R8 internal idle", 5, 32'd0, 32'(ih));
    wr(5'h18, 32'd0);
    wr(5'h0C, 32'h0C);
    restart();
    measure(30, ih, eh);
    push("R8 minimum pulse width", 5, 32'd6, 32'(ih));

    // R11 ignored writes
    wr(5'h1C, 32'h0);
    expReg(5'h1C, 32'h1, "R11 cause not writable");
    wr(5'h08, 32'h55);
    expReg(5'h08, 32'd2, "R11 counter not writable");

    // R9 forced resets
    wr(5'h0C, 32'h20);
    expPin(3, 1'b1, "R9 forced internal");
    expPin(4, 1'b0, "R9 external not forced");
    wr(5'h0C, 32'h40);
    expPin(4, 1'b1, "R9 forced external");
    expPin(3, 1'b0, "R9 internal released");
    wr(5'h0C, 32'h00);
    expPin(4, 1'b0, "R9 external released");

    // R10 power-on clears cause
    @(negedge clk);
    rstPorN = 1'b0;
    repeat (2) @(negedge clk);
    rstPorN = 1'b1;
    expReg(5'h1C, 32'h0, "R10 cause cleared by power-on");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule